// File: doc/BRIEF.md
# Fixed-point multiply-accumulate datapath

This block multiplies two 16-bit operands into a registered 32-bit product and folds that product into a single 32-bit accumulator. A scaling stage sits between the product register and the accumulator adder. It can pass the product unchanged, shift it left by one bit for fractional arithmetic, or shift it right arithmetically by six bits. The right shift leaves headroom for long runs of accumulation. The accumulator carries no extension bits. Overflow is handled by wrapping or, when enabled, by clamping, and every overflow is recorded in a sticky flag.

Operands enter as a stream qualified by `in_valid`. The block accepts a beat on every cycle, so it never applies back-pressure and has no ready output. A beat updates the product register at the next clock edge, and `prod_valid` marks that edge. The accumulator strobes act on whatever the product register holds at the edge where they are sampled, which gives a two-stage pipeline. To accumulate the product of operands presented at edge k, assert the strobe for edge k+1. The mode pins `signed_mode`, `shift_mode` and `sat_en` are plain levels. They are sampled together with the strobes.

Top module: `fxp_mac`

## Requirements
- R1: While `rst_n` is low, and directly after it rises, `acc_out`, `prod_out`, `prod_valid` and `ovf_flag` are all zero.
- R2: At a clock edge where `in_valid` is 1, `prod_out` takes the low 32 bits of `opa*opb`, and `prod_valid` equals `in_valid` from the previous edge. When `in_valid` is 0, `prod_out` keeps its value.
- R3: With `signed_mode`=1 both operands are two's complement. With `signed_mode`=0 both are unsigned. For example, 0xFFFF*0x0002 gives 0xFFFFFFFE when signed and 0x0001FFFE when unsigned.
- R4: `shift_mode` 2'b00, and the reserved code 2'b11, pass the product to the adder unshifted.
- R5: `shift_mode` 2'b01 shifts the product left by one bit, and the top bit is discarded.
- R6: `shift_mode` 2'b10 shifts the product right by six bits and copies bit 31 into the vacated bits, in both signedness modes.
- R7: At an edge, `acc_load` sets the accumulator to the scaled product, `acc_add` adds it and `acc_sub` subtracts it. With no strobe asserted, the accumulator holds its value.
- R8: Only one operation takes effect per edge, with priority clear > load > add > subtract. `acc_clr` zeroes both the accumulator and `ovf_flag`.
- R9: With `sat_en`=0, an add or subtract whose signed 32-bit result overflows wraps modulo 2^32.
- R10: With `sat_en`=1, an overflowing add or subtract clamps to 0x7FFFFFFF on a positive overflow and to 0x80000000 on a negative one.
- R11: `ovf_flag` is set by any signed overflow of an add or subtract, whether or not saturation is on. Only `acc_clr` resets it, and a load leaves it unchanged.
- R12: With the right-by-six scaling, adding 128 products of -32768*32767 gives 0x80010000 and raises no overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand beat valid, always accepted |
| opa | input | 16 | Multiplicand |
| opb | input | 16 | Multiplier |
| signed_mode | input | 1 | 1: both operands signed, 0: both unsigned |
| shift_mode | input | 2 | Product scaling: 00 none, 01 left 1, 10 right 6, 11 none |
| sat_en | input | 1 | Clamp on overflow when 1 |
| acc_load | input | 1 | Load scaled product |
| acc_add | input | 1 | Add scaled product |
| acc_sub | input | 1 | Subtract scaled product |
| acc_clr | input | 1 | Clear accumulator and overflow flag |
| acc_out | output | 32 | Accumulator value |
| prod_out | output | 32 | Product register |
| prod_valid | output | 1 | Product register was loaded at the last edge |
| ovf_flag | output | 1 | Sticky overflow flag |

## Verification
The bench builds the block with its default parameters: 16-bit operands and a six-bit right shift. These are the widths at which full-scale corner products can be driven directly. They include 0x8000*0x8000 and 0xFFFF*0xFFFF, the left shift that pushes 0x3FFF0001 to the edge of the positive range, and a 128-step accumulation that lands within 65536 of the negative limit. At these widths the bench can drive both the wrapping and the clamping paths, in both directions, through single-step overflows.

// File: rtl/fxp_mac_pkg.sv
package fxp_mac_pkg;

  typedef enum logic [1:0] {
    PSC_NONE   = 2'b00,
    PSC_LEFT1  = 2'b01,
    PSC_RIGHT  = 2'b10,
    PSC_RSVD   = 2'b11
  } pscale_e;

  typedef enum logic [2:0] {
    AOP_HOLD,
    AOP_CLEAR,
    AOP_LOAD,
    AOP_ADD,
    AOP_SUB
  } acc_op_e;

endpackage

// File: rtl/fxp_mul.sv
module fxp_mul #(
  parameter int OP_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [OP_W-1:0]   opa,
  input  logic [OP_W-1:0]   opb,
  input  logic              signed_mode,
  output logic [2*OP_W-1:0] prod,
  output logic              prod_valid
);
  localparam int P_W = 2 * OP_W;

  logic [P_W-1:0] ext_a, ext_b, full;

  always_comb begin
    ext_a = signed_mode ? {{OP_W{opa[OP_W-1]}}, opa} : {{OP_W{1'b0}}, opa};
    ext_b = signed_mode ? {{OP_W{opb[OP_W-1]}}, opb} : {{OP_W{1'b0}}, opb};
    full  = ext_a * ext_b;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prod       <= '0;
      prod_valid <= 1'b0;
    end else begin
      prod_valid <= in_valid;
      if (in_valid) prod <= full;
    end
  end

  // R2
  prod_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(prod));

  // R2
  pvalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> prod_valid);

endmodule

// File: rtl/fxp_pscale.sv
module fxp_pscale #(
  parameter int P_W = 32,
  parameter int RSH = 6
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [P_W-1:0] prod,
  input  logic [1:0]     mode,
  output logic [P_W-1:0] scaled
);
  import fxp_mac_pkg::*;

  pscale_e sel;
  assign sel = pscale_e'(mode);

  always_comb begin
    unique case (sel)
      PSC_LEFT1: scaled = {prod[P_W-2:0], 1'b0};
      PSC_RIGHT: scaled = $unsigned($signed(prod) >>> RSH);
      default:   scaled = prod;
    endcase
  end

  // R6
  rsh_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b10) |-> (scaled[P_W-1:P_W-1-RSH] == '0 ||
                         scaled[P_W-1:P_W-1-RSH] == '1));

  // R5
  lsh_lsb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b01) |-> (scaled[0] == 1'b0));

endmodule

// File: rtl/fxp_acc.sv
module fxp_acc #(
  parameter int ACC_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ACC_W-1:0] addend,
  input  logic             sat_en,
  input  logic             do_load,
  input  logic             do_add,
  input  logic             do_sub,
  input  logic             do_clr,
  output logic [ACC_W-1:0] acc,
  output logic             ovf
);
  import fxp_mac_pkg::*;

  localparam logic [ACC_W-1:0] POS_LIM = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic [ACC_W-1:0] NEG_LIM = {1'b1, {(ACC_W-1){1'b0}}};

  acc_op_e        op;
  logic [ACC_W-1:0] sum, diff, nxt;
  logic             add_ovf, sub_ovf, step_ovf;

  always_comb begin
    if (do_clr)       op = AOP_CLEAR;
    else if (do_load) op = AOP_LOAD;
    else if (do_add)  op = AOP_ADD;
    else if (do_sub)  op = AOP_SUB;
    else              op = AOP_HOLD;
  end

  always_comb begin
    sum     = acc + addend;
    diff    = acc - addend;
    add_ovf = (acc[ACC_W-1] == addend[ACC_W-1]) && (sum[ACC_W-1] != acc[ACC_W-1]);
    sub_ovf = (acc[ACC_W-1] != addend[ACC_W-1]) && (diff[ACC_W-1] != acc[ACC_W-1]);
    step_ovf = 1'b0;
    nxt      = acc;
    unique case (op)
      AOP_CLEAR: nxt = '0;
      AOP_LOAD:  nxt = addend;
      AOP_ADD: begin
        step_ovf = add_ovf;
        nxt      = sum;
      end
      AOP_SUB: begin
        step_ovf = sub_ovf;
        nxt      = diff;
      end
      default: nxt = acc;
    endcase
    if (step_ovf && sat_en) nxt = acc[ACC_W-1] ? NEG_LIM : POS_LIM;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc <= '0;
      ovf <= 1'b0;
    end else begin
      acc <= nxt;
      if (op == AOP_CLEAR) ovf <= 1'b0;
      else if (step_ovf)   ovf <= 1'b1;
    end
  end

  // R11
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !do_clr) |=> ovf);

  // R8
  clr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    do_clr |=> (acc == '0 && !ovf));

  // R7
  acc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(do_clr || do_load || do_add || do_sub) |=> $stable(acc));

  // R8
  load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (do_load && !do_clr) |=> (acc == $past(addend)));

endmodule

// File: rtl/fxp_mac.sv
module fxp_mac #(
  parameter int OP_W = 16,
  parameter int RSH  = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [OP_W-1:0]     opa,
  input  logic [OP_W-1:0]     opb,
  input  logic                signed_mode,
  input  logic [1:0]          shift_mode,
  input  logic                sat_en,
  input  logic                acc_load,
  input  logic                acc_add,
  input  logic                acc_sub,
  input  logic                acc_clr,
  output logic [2*OP_W-1:0]   acc_out,
  output logic [2*OP_W-1:0]   prod_out,
  output logic                prod_valid,
  output logic                ovf_flag
);
  localparam int ACC_W = 2 * OP_W;

  logic [ACC_W-1:0] prod_q, scaled;

  fxp_mul #(.OP_W(OP_W)) u_mul (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .opa         (opa),
    .opb         (opb),
    .signed_mode (signed_mode),
    .prod        (prod_q),
    .prod_valid  (prod_valid)
  );

  fxp_pscale #(.P_W(ACC_W), .RSH(RSH)) u_scale (
    .clk    (clk),
    .rst_n  (rst_n),
    .prod   (prod_q),
    .mode   (shift_mode),
    .scaled (scaled)
  );

  fxp_acc #(.ACC_W(ACC_W)) u_acc (
    .clk     (clk),
    .rst_n   (rst_n),
    .addend  (scaled),
    .sat_en  (sat_en),
    .do_load (acc_load),
    .do_add  (acc_add),
    .do_sub  (acc_sub),
    .do_clr  (acc_clr),
    .acc     (acc_out),
    .ovf     (ovf_flag)
  );

  assign prod_out = prod_q;

  // R1
  rst_state_chk: assert property (@(posedge clk)
    !rst_n |=> (acc_out == '0 && prod_out == '0 && !prod_valid && !ovf_flag));

endmodule

// File: tb/fxp_mac_tb.sv
`timescale 1ns/1ps
module fxp_mac_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [15:0] opa = '0, opb = '0;
  logic        signed_mode = 1'b0;
  logic [1:0]  shift_mode = 2'b00;
  logic        sat_en = 1'b0;
  logic        acc_load = 1'b0, acc_add = 1'b0, acc_sub = 1'b0, acc_clr = 1'b0;
  logic [31:0] acc_out, prod_out;
  logic        prod_valid, ovf_flag;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  fxp_mac u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opa(opa), .opb(opb),
    .signed_mode(signed_mode), .shift_mode(shift_mode), .sat_en(sat_en),
    .acc_load(acc_load), .acc_add(acc_add), .acc_sub(acc_sub), .acc_clr(acc_clr),
    .acc_out(acc_out), .prod_out(prod_out), .prod_valid(prod_valid), .ovf_flag(ovf_flag)
  );

  typedef struct {
    logic [31:0] acc;
    logic [31:0] prod;
    logic        pv;
    logic        ovf;
    string       tag;
  } exp_t;

  exp_t sb[$];

  logic [31:0] m_acc = '0, m_prod = '0;
  logic        m_ovf = 1'b0;

  task automatic step(input bit v, input logic [15:0] a, input logic [15:0] b,
                      input bit sm, input logic [1:0] shm, input bit sat,
                      input bit ld, input bit ad, input bit sb_, input bit cl,
                      input string tag);
    logic [31:0] sh;
    longint r;
    bit of;
    exp_t e;
    @(negedge clk);
    in_valid = v; opa = a; opb = b; signed_mode = sm; shift_mode = shm;
    sat_en = sat; acc_load = ld; acc_add = ad; acc_sub = sb_; acc_clr = cl;
    case (shm)
      2'b01:   sh = m_prod << 1;
      2'b10:   sh = $unsigned($signed(m_prod) >>> 6);
      default: sh = m_prod;
    endcase
    of = 1'b0;
    if (cl) begin
      m_acc = '0; m_ovf = 1'b0;
    end else if (ld) begin
      m_acc = sh;
    end else if (ad || sb_) begin
      r = ad ? longint'($signed(m_acc)) + longint'($signed(sh))
             : longint'($signed(m_acc)) - longint'($signed(sh));
      of = (r > 64'sd2147483647) || (r < -64'sd2147483648);
      if (of) m_ovf = 1'b1;
      if (of && sat) m_acc = (r > 0) ? 32'h7FFFFFFF : 32'h80000000;
      else m_acc = r[31:0];
    end
    if (v) begin
      r = sm ? longint'($signed(a)) * longint'($signed(b)) : longint'(a) * longint'(b);
      m_prod = r[31:0];
    end
    e.acc = m_acc; e.prod = m_prod; e.pv = v; e.ovf = m_ovf; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic idle(input string tag);
    step(1'b0, 16'h0, 16'h0, 1'b0, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, tag);
  endtask

  // monitor
  always @(posedge clk) begin
    #1;
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      checks++;
      if (acc_out !== e.acc || prod_out !== e.prod || prod_valid !== e.pv || ovf_flag !== e.ovf) begin
        failures++;
        $display("FAIL %s: acc=%h prod=%h pv=%b ovf=%b expected acc=%h prod=%h pv=%b ovf=%b",
                 e.tag, acc_out, prod_out, prod_valid, ovf_flag, e.acc, e.prod, e.pv, e.ovf);
      end
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [15:0] lf;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    checks++;
    // R1 reset state
    if (acc_out !== '0 || prod_out !== '0 || prod_valid !== 1'b0 || ovf_flag !== 1'b0) begin
      failures++;
      $display("FAIL R1: acc=%h prod=%h pv=%b ovf=%b expected all zero",
               acc_out, prod_out, prod_valid, ovf_flag);
    end

    // R3 signed and unsigned products; R2 hold
    step(1, 16'hFFFF, 16'h0002, 1, 2'b00, 0, 0, 0, 0, 0, "R3_signed");
    step(1, 16'hFFFF, 16'h0002, 0, 2'b00, 0, 0, 0, 0, 0, "R3_unsigned");
    step(0, 16'h1234, 16'h5678, 1, 2'b00, 0, 0, 0, 0, 0, "R2_hold");
    step(1, 16'h8000, 16'h8000, 1, 2'b00, 0, 0, 0, 0, 0, "R2_capture");

    // R4/R5/R6 scaling via load
    step(0, 16'h0, 16'h0, 0, 2'b00, 0, 1, 0, 0, 0, "R4_none");
    step(0, 16'h0, 16'h0, 0, 2'b11, 0, 1, 0, 0, 0, "R4_reserved");
    step(0, 16'h0, 16'h0, 0, 2'b10, 0, 1, 0, 0, 0, "R6_right_pos");
    step(1, 16'hFFFF, 16'hFFFF, 0, 2'b00, 0, 0, 0, 0, 0, "R2_unsigned_big");
    step(0, 16'h0, 16'h0, 0, 2'b01, 0, 1, 0, 0, 0, "R5_left_drop");
    step(0, 16'h0, 16'h0, 0, 2'b10, 0, 1, 0, 0, 0, "R6_right_unsigned");

    // R7 add/sub/hold
    step(1, 16'h0100, 16'h0003, 1, 2'b00, 0, 0, 0, 0, 1, "R8_clear");
    step(0, 16'h0, 16'h0, 1, 2'b00, 0, 0, 1, 0, 0, "R7_add");
    step(0, 16'h0, 16'h0, 1, 2'b00, 0, 0, 1, 0, 0, "R7_add2");
    step(0, 16'h0, 16'h0, 1, 2'b00, 0, 0, 0, 1, 0, "R7_sub");
    idle("R7_hold");

    // R8 priority
    step(1, 16'h0010, 16'h0010, 1, 2'b00, 0, 1, 1, 1, 0, "R8_load_over_add");
    step(0, 16'h0, 16'h0, 1, 2'b00, 0, 0, 1, 1, 0, "R8_add_over_sub");
    step(0, 16'h0, 16'h0, 1, 2'b00, 0, 1, 1, 1, 1, "R8_clear_over_all");

    // R9/R11 wrap on positive overflow
    step(1, 16'h7FFF, 16'h7FFF, 1, 2'b00, 0, 0, 0, 0, 0, "R2_max");
    step(0, 16'h0, 16'h0, 1, 2'b01, 0, 1, 0, 0, 0, "R5_frac_load");
    step(0, 16'h0, 16'h0, 1, 2'b01, 0, 0, 1, 0, 0, "R9_wrap_pos");
    step(0, 16'h0, 16'h0, 1, 2'b01, 0, 1, 0, 0, 0, "R11_load_keeps_flag");
    step(0, 16'h0, 16'h0, 1, 2'b01, 1, 0, 1, 0, 0, "R10_clamp_pos");
    step(0, 16'h0, 16'h0, 1, 2'b01, 0, 0, 0, 0, 1, "R11_clear_flag");

    // R10 negative clamp via subtract
    step(1, 16'h8000, 16'h7FFF, 1, 2'b00, 0, 0, 0, 0, 0, "R2_neg");
    step(1, 16'h7FFF, 16'h7FFF, 1, 2'b01, 0, 1, 0, 0, 0, "R5_neg_load");
    step(0, 16'h0, 16'h0, 1, 2'b01, 1, 0, 0, 1, 0, "R10_clamp_neg");
    step(0, 16'h0, 16'h0, 1, 2'b00, 0, 0, 0, 0, 1, "R11_clear2");
    step(1, 16'h8000, 16'h7FFF, 1, 2'b00, 0, 0, 0, 0, 0, "R2_neg2");
    step(0, 16'h0, 16'h0, 1, 2'b01, 0, 1, 0, 0, 0, "R9_setup_neg");
    step(1, 16'h7FFF, 16'h7FFF, 1, 2'b01, 0, 0, 0, 0, 0, "R9_prod");
    step(0, 16'h0, 16'h0, 1, 2'b01, 0, 0, 0, 1, 0, "R9_wrap_neg");

    // R12 128 accumulations with right scaling
    step(1, 16'h8000, 16'h7FFF, 1, 2'b00, 0, 0, 0, 0, 1, "R12_setup");
    for (int i = 0; i < 128; i++)
      step(0, 16'h0, 16'h0, 1, 2'b10, 0, 0, 1, 0, 0, "R12_accumulate");
    idle("R12_final");

    // R7 mixed patterns
    lf = 16'hACE1;
    for (int i = 0; i < 60; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      step(1, lf, {lf[7:0], lf[15:8]}, lf[0], lf[2:1], lf[3],
           lf[4] & lf[5], lf[6], lf[7], (lf[9:8] == 2'b11) & lf[10], "R7_mixed");
    end
    idle("R7_drain");
    @(negedge clk);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule